// File: doc/BRIEF.md
# Hot-plug slot event register

This block holds the per-slot status, event and mask words of a hot-plug controller, together with the controller-wide interrupt locator and interrupt/SERR control word. It samples the physical slot pins through synchronizers. These pins are the two presence-detect pins, the retention-latch (MRL) sensor, the attention button, and an isolated and a connected power-fault flag. Their changes are caught as sticky event bits that software clears by writing 1.

Each event has its own interrupt mask. Two of them, MRL change and connected power fault, also have SERR masks. A slot whose unmasked events are pending lights its locator bit. The interrupt output is the OR of all locator bits, held off while the global interrupt mask is set. The status fields that come from the power-sequencing logic (slot state, indicator states, capability bits) enter as synchronous inputs and read back live.

Software reaches the words through a 32-bit port with a registered read. Word 0 is the locator, word 1 is the controller word, and word 2+i belongs to slot i.

Top module: `hp_slot_evt_regs`

## Requirements
- R1: A slot word reads its live fields: [1:0] slot state (1 power-only, 2 enabled, 3 disabled), [3:2] power indicator, [5:4] attention indicator (1 on, 2 blink, 3 off), bit 6 power-good (0 while either fault input is high), bit 7 button, bit 8 MRL open, bit 9 66 MHz capable, [11:10] presence pins (3 = empty), and [14:12] PCI-X capability (bit 14 reads 0 when PROG_IF is 1).
- R2: Event bit 16 sets whenever the synchronized 2-bit presence value differs from its value one clock earlier.
- R3: Event bit 19 sets on either edge of the MRL sensor. Bit 18 sets on a rising edge of the button, bit 17 on a rising edge of the isolated fault, and bit 20 on a rising edge of the connected fault. Falling edges and held levels of these three inputs set nothing.
- R4: Writing 1 to an event bit (16 to 20) clears it, and writing 0 leaves it unchanged. If a new event arrives in the same cycle as the clear, the bit stays set.
- R5: Bits 24 to 28 are interrupt masks for events 16 to 20 in that order, and bits 29 and 30 are the SERR masks for MRL change and connected fault. All of these are read/write. After reset every mask in the slot and controller words is 1 and every event bit is 0.
- R6: In a slot word, bits 15, 23:21 and 31 read as 0 and ignore writes. In the controller word, bits 15:4 and 31:18 do the same.
- R7: Locator bit 0 is the command-complete bit ANDed with the inverted command mask. Locator bit i+1 is 1 when slot i has any event bit set whose interrupt mask is 0.
- R8: irq_o is registered. It equals the OR of the locator bits one cycle later and is 0 whenever the global interrupt mask (controller bit 0) was 1.
- R9: In the controller word, bits 3:0 are the global interrupt, global SERR, command interrupt and arbiter SERR masks. Bit 16 is set by a cmd_done_i pulse and bit 17 by an arb_timeout_i pulse, and both are cleared by writing 1.
- R10: serr_o is registered. It is 1 when the global SERR mask is 0 and at least one of these holds: a slot has an MRL-change event with its MRL SERR mask at 0, a slot has a connected-fault event with that SERR mask at 0, or the arbiter bit is set with the arbiter SERR mask at 0.
- R11: A read with reg_rd high returns the addressed word on reg_rdata one cycle later. Unmapped addresses return 0, and reg_rdata is 0 in any cycle after one without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Word index |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| slot_state_i | input | 2*NUM_SLOTS | Slot state per slot |
| slot_pwr_ind_i | input | 2*NUM_SLOTS | Power indicator state per slot |
| slot_attn_ind_i | input | 2*NUM_SLOTS | Attention indicator state per slot |
| slot_cap66_i | input | NUM_SLOTS | 66 MHz capable per slot |
| slot_pcix_i | input | 3*NUM_SLOTS | PCI-X capability code per slot |
| slot_prsnt_i | input | 2*NUM_SLOTS | Presence pins per slot (asynchronous) |
| slot_button_i | input | NUM_SLOTS | Attention button, 1 = pressed (asynchronous) |
| slot_mrl_open_i | input | NUM_SLOTS | MRL sensor, 1 = open (asynchronous) |
| slot_iso_fault_i | input | NUM_SLOTS | Isolated power fault, 1 = fault (asynchronous) |
| slot_con_fault_i | input | NUM_SLOTS | Connected power fault, 1 = fault (asynchronous) |
| cmd_done_i | input | 1 | One-cycle command-complete pulse |
| arb_timeout_i | input | 1 | One-cycle arbiter time-out pulse |
| irq_o | output | 1 | Interrupt request |
| serr_o | output | 1 | SERR request |

## Verification
The assertions assume that cmd_done_i and arb_timeout_i are single-cycle pulses synchronous to clk and that reset is held for at least one edge from time zero. They also assume reg_rd is only high for one cycle per access, so that an idle cycle always precedes the zero read-data check. The bench drives every input on the falling edge and issues each read and write as a one-cycle strobe. It pulses the two controller events for exactly one cycle and changes the slot pins only between accesses. The one deliberate overlap lines up a clear with the edge on which a presence event lands.

// File: rtl/hp_evt_pkg.sv
`timescale 1ns/1ps
package hp_evt_pkg;
  localparam int REG_W = 32;

  // slot word live fields
  localparam int B_STATE  = 0;
  localparam int B_PIND   = 2;
  localparam int B_AIND   = 4;
  localparam int B_PGOOD  = 6;
  localparam int B_BTN    = 7;
  localparam int B_MRL    = 8;
  localparam int B_CAP66  = 9;
  localparam int B_PRSNT  = 10;
  localparam int B_PCIX   = 12;

  // event indices, offsets from the event / mask base
  localparam int NUM_EV   = 5;
  localparam int EV_PRSNT = 0;
  localparam int EV_ISOF  = 1;
  localparam int EV_BTN   = 2;
  localparam int EV_MRL   = 3;
  localparam int EV_CONF  = 4;
  localparam int B_EVT    = 16;
  localparam int B_IMSK   = 24;
  localparam int B_SMSK   = 29;
  localparam int NUM_SMSK = 2;

  // controller word
  localparam int C_MSK    = 0;
  localparam int NUM_CMSK = 4;
  localparam int C_GIMSK  = 0;
  localparam int C_GSMSK  = 1;
  localparam int C_CMSK   = 2;
  localparam int C_AMSK   = 3;
  localparam int C_DET    = 16;

  // word map
  localparam int A_LOC    = 0;
  localparam int A_CTL    = 1;
  localparam int A_SLOT0  = 2;
endpackage

// File: rtl/hp_sync.sv
`timescale 1ns/1ps
module hp_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) pipe[k] <= '0;
    end else begin
      pipe[0] <= d;
      for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/hp_slot_evt.sv
`timescale 1ns/1ps
module hp_slot_evt
  import hp_evt_pkg::*;
#(
  parameter int PROG_IF     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          state,
  input  logic [1:0]          pwr_ind,
  input  logic [1:0]          attn_ind,
  input  logic                cap66,
  input  logic [2:0]          pcix,
  input  logic [1:0]          prsnt,
  input  logic                button,
  input  logic                mrl_open,
  input  logic                iso_fault,
  input  logic                con_fault,
  input  logic                wr_en,
  input  logic [NUM_EV-1:0]   wd_clr,
  input  logic [NUM_EV-1:0]   wd_imsk,
  input  logic [NUM_SMSK-1:0] wd_smsk,
  output logic [REG_W-1:0]    word,
  output logic                pend,
  output logic                serr_req
);
  localparam int PIN_W = 6;

  logic [PIN_W-1:0]    pins_s, pins_prev;
  logic [NUM_EV-1:0]   hit, evt, imsk;
  logic [NUM_SMSK-1:0] smsk;
  logic [2:0]          pcix_rd;

  // pin order: [1:0] presence, 2 mrl, 3 button, 4 iso fault, 5 con fault
  hp_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({con_fault, iso_fault, button, mrl_open, prsnt}),
    .q   (pins_s)
  );

  always_ff @(posedge clk) begin
    if (rst) pins_prev <= '0;
    else     pins_prev <= pins_s;
  end

  always_comb begin
    hit           = '0;
    hit[EV_PRSNT] = pins_s[1:0] != pins_prev[1:0];
    hit[EV_MRL]   = pins_s[2] ^ pins_prev[2];
    hit[EV_BTN]   = pins_s[3] & ~pins_prev[3];
    hit[EV_ISOF]  = pins_s[4] & ~pins_prev[4];
    hit[EV_CONF]  = pins_s[5] & ~pins_prev[5];
  end

  for (genvar e = 0; e < NUM_EV; e++) begin : g_evt
    always_ff @(posedge clk) begin
      if (rst) evt[e] <= 1'b0;
      else     evt[e] <= hit[e] | (evt[e] & ~(wr_en & wd_clr[e]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      imsk <= '1;
      smsk <= '1;
    end else if (wr_en) begin
      imsk <= wd_imsk;
      smsk <= wd_smsk;
    end
  end

  if (PROG_IF == 1) begin : g_pi1
    logic pcix_unused;
    assign pcix_unused = pcix[2];
    assign pcix_rd     = {1'b0, pcix[1:0]};
  end else begin : g_pi2
    assign pcix_rd = pcix;
  end

  always_comb begin
    word                          = '0;
    word[B_STATE +: 2]            = state;
    word[B_PIND  +: 2]            = pwr_ind;
    word[B_AIND  +: 2]            = attn_ind;
    word[B_PGOOD]                 = ~(pins_s[4] | pins_s[5]);
    word[B_BTN]                   = pins_s[3];
    word[B_MRL]                   = pins_s[2];
    word[B_CAP66]                 = cap66;
    word[B_PRSNT +: 2]            = pins_s[1:0];
    word[B_PCIX  +: 3]            = pcix_rd;
    word[B_EVT   +: NUM_EV]       = evt;
    word[B_IMSK  +: NUM_EV]       = imsk;
    word[B_SMSK  +: NUM_SMSK]     = smsk;
  end

  assign pend     = |(evt & ~imsk);
  assign serr_req = (evt[EV_MRL] & ~smsk[0]) | (evt[EV_CONF] & ~smsk[1]);
endmodule

// File: rtl/hp_ctl_evt.sv
`timescale 1ns/1ps
module hp_ctl_evt
  import hp_evt_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [NUM_CMSK-1:0] wd_msk,
  input  logic [1:0]          wd_clr,
  input  logic                cmd_done,
  input  logic                arb_timeout,
  output logic [REG_W-1:0]    word,
  output logic                gimsk,
  output logic                gsmsk,
  output logic                cmd_pend,
  output logic                arb_serr
);
  logic [NUM_CMSK-1:0] msk;
  logic                cdet, adet;

  always_ff @(posedge clk) begin
    if (rst) begin
      msk  <= '1;
      cdet <= 1'b0;
      adet <= 1'b0;
    end else begin
      if (wr_en) msk <= wd_msk;
      cdet <= cmd_done    | (cdet & ~(wr_en & wd_clr[0]));
      adet <= arb_timeout | (adet & ~(wr_en & wd_clr[1]));
    end
  end

  always_comb begin
    word                    = '0;
    word[C_MSK +: NUM_CMSK] = msk;
    word[C_DET]             = cdet;
    word[C_DET+1]           = adet;
  end

  assign gimsk    = msk[C_GIMSK];
  assign gsmsk    = msk[C_GSMSK];
  assign cmd_pend = cdet & ~msk[C_CMSK];
  assign arb_serr = adet & ~msk[C_AMSK];
endmodule

// File: rtl/hp_slot_evt_regs.sv
`timescale 1ns/1ps
module hp_slot_evt_regs
  import hp_evt_pkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int ADDR_W      = 4,
  parameter int PROG_IF     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [ADDR_W-1:0]      reg_addr,
  input  logic                   reg_wr,
  input  logic                   reg_rd,
  input  logic [31:0]            reg_wdata,
  output logic [31:0]            reg_rdata,
  input  logic [2*NUM_SLOTS-1:0] slot_state_i,
  input  logic [2*NUM_SLOTS-1:0] slot_pwr_ind_i,
  input  logic [2*NUM_SLOTS-1:0] slot_attn_ind_i,
  input  logic [NUM_SLOTS-1:0]   slot_cap66_i,
  input  logic [3*NUM_SLOTS-1:0] slot_pcix_i,
  input  logic [2*NUM_SLOTS-1:0] slot_prsnt_i,
  input  logic [NUM_SLOTS-1:0]   slot_button_i,
  input  logic [NUM_SLOTS-1:0]   slot_mrl_open_i,
  input  logic [NUM_SLOTS-1:0]   slot_iso_fault_i,
  input  logic [NUM_SLOTS-1:0]   slot_con_fault_i,
  input  logic                   cmd_done_i,
  input  logic                   arb_timeout_i,
  output logic                   irq_o,
  output logic                   serr_o
);
  localparam int LOC_W = NUM_SLOTS + 1;

  logic [REG_W-1:0]     slot_word [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] slot_wr, slot_pend, slot_serr;
  logic [REG_W-1:0]     ctl_word, rd_mux;
  logic [LOC_W-1:0]     loc_vec;
  logic                 loc_any;
  logic                 ctl_wr, gimsk, gsmsk, cmd_pend, arb_serr;
  logic                 wdata_unused;

  assign wdata_unused = ^{reg_wdata[31], reg_wdata[23:21], reg_wdata[15:4]};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign slot_wr[i] = reg_wr && (reg_addr == ADDR_W'(A_SLOT0 + i));

    hp_slot_evt #(.PROG_IF(PROG_IF), .SYNC_STAGES(SYNC_STAGES)) u_slot (
      .clk       (clk),
      .rst       (rst),
      .state     (slot_state_i[2*i +: 2]),
      .pwr_ind   (slot_pwr_ind_i[2*i +: 2]),
      .attn_ind  (slot_attn_ind_i[2*i +: 2]),
      .cap66     (slot_cap66_i[i]),
      .pcix      (slot_pcix_i[3*i +: 3]),
      .prsnt     (slot_prsnt_i[2*i +: 2]),
      .button    (slot_button_i[i]),
      .mrl_open  (slot_mrl_open_i[i]),
      .iso_fault (slot_iso_fault_i[i]),
      .con_fault (slot_con_fault_i[i]),
      .wr_en     (slot_wr[i]),
      .wd_clr    (reg_wdata[B_EVT +: NUM_EV]),
      .wd_imsk   (reg_wdata[B_IMSK +: NUM_EV]),
      .wd_smsk   (reg_wdata[B_SMSK +: NUM_SMSK]),
      .word      (slot_word[i]),
      .pend      (slot_pend[i]),
      .serr_req  (slot_serr[i])
    );
  end

  assign ctl_wr = reg_wr && (reg_addr == ADDR_W'(A_CTL));

  hp_ctl_evt u_ctl (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (ctl_wr),
    .wd_msk      (reg_wdata[C_MSK +: NUM_CMSK]),
    .wd_clr      (reg_wdata[C_DET +: 2]),
    .cmd_done    (cmd_done_i),
    .arb_timeout (arb_timeout_i),
    .word        (ctl_word),
    .gimsk       (gimsk),
    .gsmsk       (gsmsk),
    .cmd_pend    (cmd_pend),
    .arb_serr    (arb_serr)
  );

  assign loc_vec = {slot_pend, cmd_pend};
  assign loc_any = |loc_vec;

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(A_LOC))      rd_mux = REG_W'(loc_vec);
    else if (reg_addr == ADDR_W'(A_CTL)) rd_mux = ctl_word;
    for (int i = 0; i < NUM_SLOTS; i++)
      if (reg_addr == ADDR_W'(A_SLOT0 + i)) rd_mux = slot_word[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
      irq_o     <= 1'b0;
      serr_o    <= 1'b0;
    end else begin
      reg_rdata <= reg_rd ? rd_mux : '0;
      irq_o     <= loc_any & ~gimsk;
      serr_o    <= ~gsmsk & ((|slot_serr) | arb_serr);
    end
  end
endmodule

// File: rtl/hp_slot_evt_chk.sv
`timescale 1ns/1ps
module hp_slot_evt_chk (
  input logic        clk,
  input logic        rst,
  input logic        reg_rd,
  input logic [31:0] reg_rdata,
  input logic        irq_o,
  input logic        serr_o,
  input logic [31:0] ctl_word,
  input logic        loc_any,
  input logic        cmd_done_i
);
  assert_reset_masks_R5: assert property (@(posedge clk)
    rst |=> (ctl_word[3:0] == 4'hF) && !irq_o && !serr_o);

  assert_rd_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !reg_rd |=> (reg_rdata == 32'h0));

  assert_irq_gated_R8: assert property (@(posedge clk) disable iff (rst)
    ctl_word[0] |=> !irq_o);

  assert_irq_raise_R8: assert property (@(posedge clk) disable iff (rst)
    (!ctl_word[0] && loc_any) |=> irq_o);

  assert_serr_gated_R10: assert property (@(posedge clk) disable iff (rst)
    ctl_word[1] |=> !serr_o);

  assert_cmd_latch_R9: assert property (@(posedge clk) disable iff (rst)
    cmd_done_i |=> ctl_word[16]);
endmodule

bind hp_slot_evt_regs hp_slot_evt_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .reg_rd     (reg_rd),
  .reg_rdata  (reg_rdata),
  .irq_o      (irq_o),
  .serr_o     (serr_o),
  .ctl_word   (ctl_word),
  .loc_any    (loc_any),
  .cmd_done_i (cmd_done_i)
);

// File: tb/tb_hp_slot_evt_regs.sv
`timescale 1ns/1ps
module tb_hp_slot_evt_regs;
  localparam int NS = 4;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [AW-1:0]   reg_addr = '0;
  logic            reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [2*NS-1:0] slot_state_i, slot_pwr_ind_i, slot_attn_ind_i, slot_prsnt_i;
  logic [NS-1:0]   slot_cap66_i, slot_button_i, slot_mrl_open_i, slot_iso_fault_i, slot_con_fault_i;
  logic [3*NS-1:0] slot_pcix_i;
  logic            cmd_done_i = 1'b0, arb_timeout_i = 1'b0;
  logic            irq_o, serr_o;

  logic [1:0] b_state [NS];
  logic [1:0] b_pind  [NS];
  logic [1:0] b_aind  [NS];
  logic [1:0] b_prsnt [NS];
  logic [2:0] b_pcix  [NS];
  logic       b_cap   [NS];
  logic       b_btn   [NS];
  logic       b_mrl   [NS];
  logic       b_iso   [NS];
  logic       b_con   [NS];

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      slot_state_i[2*i +: 2]    = b_state[i];
      slot_pwr_ind_i[2*i +: 2]  = b_pind[i];
      slot_attn_ind_i[2*i +: 2] = b_aind[i];
      slot_prsnt_i[2*i +: 2]    = b_prsnt[i];
      slot_pcix_i[3*i +: 3]     = b_pcix[i];
      slot_cap66_i[i]           = b_cap[i];
      slot_button_i[i]          = b_btn[i];
      slot_mrl_open_i[i]        = b_mrl[i];
      slot_iso_fault_i[i]       = b_iso[i];
      slot_con_fault_i[i]       = b_con[i];
    end
  end

  hp_slot_evt_regs #(.NUM_SLOTS(NS), .ADDR_W(AW)) dut (.*);

  int checks = 0;
  int fails  = 0;

  // {write, addr, data}; for reads, data is the expected word
  localparam logic [36:0] VEC [15] = '{
    {1'b0, 4'd1,  32'h0000000F},
    {1'b0, 4'd2,  32'h7F002276},
    {1'b1, 4'd2,  32'hFFFFFFFF},
    {1'b0, 4'd2,  32'h7F002276},
    {1'b1, 4'd3,  32'h00000000},
    {1'b0, 4'd3,  32'h00002276},
    {1'b0, 4'd2,  32'h7F002276},
    {1'b1, 4'd1,  32'hFFFFFFFF},
    {1'b0, 4'd1,  32'h0000000F},
    {1'b1, 4'd1,  32'h00000000},
    {1'b0, 4'd1,  32'h00000000},
    {1'b0, 4'd0,  32'h00000000},
    {1'b0, 4'd15, 32'h00000000},
    {1'b1, 4'd3,  32'h7F000000},
    {1'b0, 4'd3,  32'h7F002276}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = AW'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] stat(input int i);
    logic [31:0] w = '0;
    w[1:0]   = b_state[i];
    w[3:2]   = b_pind[i];
    w[5:4]   = b_aind[i];
    w[6]     = ~(b_iso[i] | b_con[i]);
    w[7]     = b_btn[i];
    w[8]     = b_mrl[i];
    w[9]     = b_cap[i];
    w[11:10] = b_prsnt[i];
    w[14:12] = b_pcix[i];
    return w;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int i = 0; i < NS; i++) begin
      b_state[i] = 2'd2; b_pind[i] = 2'd1; b_aind[i] = 2'd3; b_prsnt[i] = 2'd0;
      b_pcix[i] = 3'd2; b_cap[i] = 1'b1; b_btn[i] = 1'b0; b_mrl[i] = 1'b0;
      b_iso[i] = 1'b0; b_con[i] = 1'b0;
    end
    repeat (4) @(negedge clk);
    rst = 1'b0;
    settle(4);

    // reset state
    chk("R5 irq after reset", {31'd0, irq_o}, 32'd0);
    chk("R10 serr after reset", {31'd0, serr_o}, 32'd0);
    chk("R11 idle rdata", reg_rdata, 32'd0);

    // table walk: R5 R6 R9 R11 register access
    for (int k = 0; k < 15; k++) begin
      if (VEC[k][36]) wr(int'(VEC[k][35:32]), VEC[k][31:0]);
      else begin
        rd(int'(VEC[k][35:32]), d);
        chk($sformatf("R5 R6 R11 table row %0d", k), d, VEC[k][31:0]);
      end
    end

    // R2 presence change, R7 locator, R8 irq
    wr(2, 32'h7E000000);
    b_prsnt[0] = 2'd1;
    settle(6);
    rd(2, d); chk("R2 presence event", d, stat(0) | 32'h7E010000);
    chk("R8 irq raised", {31'd0, irq_o}, 32'd1);
    rd(0, d); chk("R7 locator slot0", d, 32'h2);

    // R4 writing zero keeps, writing one clears
    wr(2, 32'h7E000000);
    rd(2, d); chk("R4 zero write keeps event", d, stat(0) | 32'h7E010000);
    wr(2, 32'h7E010000);
    settle(2);
    rd(2, d); chk("R4 clear by one", d, stat(0) | 32'h7E000000);
    chk("R8 irq dropped", {31'd0, irq_o}, 32'd0);

    // R4 clear in the same edge as a new event
    @(negedge clk); b_prsnt[0] = 2'd0;
    @(negedge clk);
    @(negedge clk);
    reg_addr = 4'd2; reg_wdata = 32'h7E010000; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    settle(4);
    rd(2, d); chk("R4 set wins over clear", d, stat(0) | 32'h7E010000);
    wr(2, 32'h7E010000);

    // R3 button edges on slot 1
    wr(3, 32'h7B000000);
    b_btn[1] = 1'b1; settle(6);
    rd(3, d); chk("R3 button press", d, stat(1) | 32'h7B040000);
    wr(3, 32'h7B040000);
    b_btn[1] = 1'b0; settle(6);
    rd(3, d); chk("R3 button release ignored", d, stat(1) | 32'h7B000000);

    // R3 MRL both edges
    b_mrl[1] = 1'b1; settle(6);
    rd(3, d); chk("R3 mrl open", d, stat(1) | 32'h7B080000);
    wr(3, 32'h7B080000);
    b_mrl[1] = 1'b0; settle(6);
    rd(3, d); chk("R3 mrl close", d, stat(1) | 32'h7B080000);
    wr(3, 32'h7B080000);

    // R3 faults, R1 power-good low
    b_iso[1] = 1'b1; settle(6);
    rd(3, d); chk("R3 R1 iso fault", d, stat(1) | 32'h7B020000);
    wr(3, 32'h7B020000); settle(6);
    rd(3, d); chk("R3 held fault no retrigger", d, stat(1) | 32'h7B000000);
    b_iso[1] = 1'b0; settle(6);
    b_con[1] = 1'b1; settle(6);
    rd(3, d); chk("R3 con fault", d, stat(1) | 32'h7B100000);
    rd(0, d); chk("R7 masked event not pending", d, 32'h0);
    wr(3, 32'h7B100000);
    b_con[1] = 1'b0; settle(6);

    // R10 SERR from MRL change
    wr(3, 32'h5F000000);
    b_mrl[1] = 1'b1; settle(6);
    chk("R10 serr on mrl", {31'd0, serr_o}, 32'd1);
    chk("R8 irq stays low when masked", {31'd0, irq_o}, 32'd0);
    wr(1, 32'h2); settle(2);
    chk("R10 serr global mask", {31'd0, serr_o}, 32'd0);
    wr(1, 32'h0);
    wr(3, 32'h7F080000); settle(2);
    chk("R10 serr after clear", {31'd0, serr_o}, 32'd0);

    // R9 command complete, R7 bit 0, R8 global mask
    @(negedge clk); cmd_done_i = 1'b1;
    @(negedge clk); cmd_done_i = 1'b0;
    settle(2);
    rd(1, d); chk("R9 command detected", d, 32'h00010000);
    rd(0, d); chk("R7 locator bit0", d, 32'h1);
    chk("R8 irq from command", {31'd0, irq_o}, 32'd1);
    wr(1, 32'h1); settle(2);
    chk("R8 global mask", {31'd0, irq_o}, 32'd0);
    rd(0, d); chk("R7 locator under global mask", d, 32'h1);
    wr(1, 32'h00010001);
    rd(1, d); chk("R9 command clear", d, 32'h1);
    wr(1, 32'h0);
    @(negedge clk); arb_timeout_i = 1'b1;
    @(negedge clk); arb_timeout_i = 1'b0;
    settle(2);
    rd(1, d); chk("R9 arbiter detected", d, 32'h00020000);
    chk("R10 serr from arbiter", {31'd0, serr_o}, 32'd1);
    wr(1, 32'h00020000); settle(2);
    rd(1, d); chk("R9 arbiter clear", d, 32'h0);

    // R1 live fields, R6 reserved bits on slot 3
    b_state[3] = 2'd1; b_pind[3] = 2'd2; b_aind[3] = 2'd1; b_cap[3] = 1'b0; b_pcix[3] = 3'd5;
    settle(2);
    rd(5, d); chk("R1 live fields", d, stat(3) | 32'h7F000000);
    wr(5, 32'hFFE08000);
    rd(5, d); chk("R6 reserved ignored", d, stat(3) | 32'h7F000000);

    // R7 two slots pending
    wr(4, 32'h7E000000);
    b_prsnt[2] = 2'd2; b_prsnt[0] = 2'd1;
    settle(6);
    rd(0, d); chk("R7 two slots", d, 32'hA);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule